// File: doc/BRIEF.md
# Configuration Stream Command Parser

This block sits at the front of a device configuration path and receives a byte stream, one byte per accepted cycle. Everything before a 32-bit synchronisation token is ignored, so a header with free-form zero-terminated text, and a closing marker that may turn up in the wrong place, is passed over without any parsing. Once the token has been seen, the block decodes a sequence of commands. Each command byte carries an opcode in its upper nibble and, in its lower nibble, the number of argument bytes that follow. The argument is assembled most significant byte first.

Commands update a set of decoded configuration registers: bank select, bank width, height and offset, boot address, oscillator range, and warm and cold boot enables. Memory write commands open a data block whose length is width times height divided by eight. The block forwards those bytes to an external loader and then consumes a two-byte zero trailer. A running CRC-16 covers every byte after the token. It can be reloaded by a command, and a check command flags a mismatch. Protocol violations raise a sticky error flag, and a wakeup command produces a one-cycle pulse.

Top module: `cfg_stream_parser`

## Requirements
- R1: Before the token 0x7E,0xAA,0x99,0x7E has arrived in that byte order, every byte is ignored. This includes stray 0x00/0xFF markers and bytes that look like commands. `synced` rises one cycle after the last token byte is accepted and stays high until reset.
- R2: A command byte holds the opcode in bits 7:4 and the argument byte count in bits 3:0. The argument is assembled MSB first, and a count of 0 means the value 0. Opcode 1 loads `bank_num`, 6 loads `bank_width`, 7 loads `bank_height`, 8 loads `bank_offset` and 4 loads `boot_addr`. Each update is visible one cycle after the last argument byte.
- R3: Opcode 5 loads `osc_range` with the values 0 (low), 1 (medium) or 2 (high). A larger value leaves `osc_range` unchanged and sets `proto_err`.
- R4: Opcode 9 with value 32 sets `warm_boot_en`, value 16 sets `cold_boot_en`, and value 0 clears `warm_boot_en` while leaving `cold_boot_en` as it is.
- R5: Opcode 0 with value 1 (configuration memory, `blk_is_bram`=0) or value 3 (block memory, `blk_is_bram`=1) opens a data block. The next width*height/8 bytes each appear on `blk_byte` with `blk_valid` high one cycle after they are accepted. The two trailer bytes that follow are not forwarded, and a nonzero trailer byte sets `proto_err`. Command decoding then resumes.
- R6: The CRC is CRC-16 with polynomial 0x1021, processed MSB first with no reflection. It is loaded with 0xFFFF when the token is found and is updated over every later byte: commands, arguments, data and trailers. Opcode 0 with value 5 loads 0xFFFF after its own bytes have been absorbed.
- R7: Opcode 2 sets the sticky `crc_err` if the CRC is nonzero once its argument bytes have been absorbed. Sending the running CRC, MSB first, as a two-byte argument leaves `crc_err` clear.
- R8: The undefined opcodes 3 and 10 to 15 set the sticky `proto_err`, and so do opcode 0 values other than 1 to 6 and 8, and opcode 9 values other than 0, 16 and 32. Their argument bytes are consumed, and the next command decodes normally. Opcode 0 values 2, 4 and 8 are accepted without any effect on the outputs.
- R9: Opcode 0 with value 6 drives `wake_pulse` high for exactly one cycle, the cycle after its last byte is accepted.
- R10: After reset, `synced`, all configuration registers, `blk_valid`, `wake_pulse`, `proto_err` and `crc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A stream byte is presented this cycle |
| in_byte | input | 8 | Stream byte |
| synced | output | 1 | Token found; commands are being decoded |
| bank_num | output | BANK_W | Selected bank |
| bank_width | output | DIM_W | Bank width |
| bank_height | output | DIM_W | Bank height |
| bank_offset | output | DIM_W | Bank vertical offset |
| boot_addr | output | BOOT_W | Boot address |
| osc_range | output | 2 | Oscillator range: 0 low, 1 medium, 2 high |
| warm_boot_en | output | 1 | Warm boot enabled |
| cold_boot_en | output | 1 | Cold boot enabled |
| blk_valid | output | 1 | Data block byte for the loader |
| blk_byte | output | 8 | Data block byte |
| blk_is_bram | output | 1 | Current block targets block memory |
| wake_pulse | output | 1 | One-cycle wakeup request |
| proto_err | output | 1 | Sticky protocol error |
| crc_err | output | 1 | Sticky CRC mismatch |

## Verification
The hardest situation to reach from the ports is a passing CRC check. The check value depends on every byte since the token or since the last CRC reload, including the check command byte itself. The bench therefore keeps its own CRC over every byte it sends after the token and sends that value, MSB first, right after the check opcode. It then sends a deliberately inverted value to force a failure. The data block path is reached by first loading a small width and height, so that the block is two bytes long and its trailer boundary is exercised directly.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_CMD,
      ST_ARG,
      ST_DATA,
      ST_TRAIL
   } prs_state_t;

   localparam logic [3:0] OP_SYS      = 4'd0;
   localparam logic [3:0] OP_BANK     = 4'd1;
   localparam logic [3:0] OP_CRCCHK   = 4'd2;
   localparam logic [3:0] OP_BOOTADDR = 4'd4;
   localparam logic [3:0] OP_OSC      = 4'd5;
   localparam logic [3:0] OP_WIDTH    = 4'd6;
   localparam logic [3:0] OP_HEIGHT   = 4'd7;
   localparam logic [3:0] OP_OFFSET   = 4'd8;
   localparam logic [3:0] OP_BOOTMODE = 4'd9;

   localparam int unsigned SUB_CFG_WR  = 1;
   localparam int unsigned SUB_RD_A    = 2;
   localparam int unsigned SUB_RAM_WR  = 3;
   localparam int unsigned SUB_RD_B    = 4;
   localparam int unsigned SUB_CRC_CLR = 5;
   localparam int unsigned SUB_WAKE    = 6;
   localparam int unsigned SUB_REBOOT  = 8;

   localparam int unsigned BM_WARM_OFF = 0;
   localparam int unsigned BM_COLD_ON  = 16;
   localparam int unsigned BM_WARM_ON  = 32;

   localparam int unsigned OSC_MAX = 2;

   function automatic logic opcode_known(input logic [3:0] op);
      case (op)
         OP_SYS, OP_BANK, OP_CRCCHK, OP_BOOTADDR, OP_OSC,
         OP_WIDTH, OP_HEIGHT, OP_OFFSET, OP_BOOTMODE: opcode_known = 1'b1;
         default:                                     opcode_known = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cfgp_sync_hunt.sv
module cfgp_sync_hunt #(
   parameter int unsigned         SYNC_BYTES = 4,
   parameter logic [8*SYNC_BYTES-1:0] SYNC_WORD = 32'h7EAA997E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hunting,
   input  logic       shift,
   input  logic [7:0] byte_in,
   output logic       hit
);
   localparam int unsigned WIN_W  = 8 * SYNC_BYTES;
   localparam int unsigned FILL_W = $clog2(SYNC_BYTES + 1);

   logic [WIN_W-1:0]  win_q;
   logic [WIN_W-1:0]  win_nx;
   logic [FILL_W-1:0] fill_q;
   logic              full_nx;

   generate
      if (SYNC_BYTES == 1) begin : g_single
         assign win_nx = byte_in;
      end else begin : g_multi
         assign win_nx = {win_q[WIN_W-9:0], byte_in};
      end
   endgenerate

   assign full_nx = (fill_q >= FILL_W'(SYNC_BYTES - 1));
   assign hit     = hunting && shift && full_nx && (win_nx == SYNC_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (hunting && shift) begin
         win_q <= win_nx;
         if (fill_q != FILL_W'(SYNC_BYTES)) begin
            fill_q <= fill_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfgp_crc16.sv
module cfgp_crc16 #(
   parameter int unsigned     CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_init,
   input  logic             absorb,
   input  logic [7:0]       byte_in,
   output logic [CRC_W-1:0] crc_nx
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stepped;

   always_comb begin
      stepped = crc_q;
      for (int b = 7; b >= 0; b--) begin
         if (stepped[CRC_W-1] ^ byte_in[b]) begin
            stepped = {stepped[CRC_W-2:0], 1'b0} ^ POLY;
         end else begin
            stepped = {stepped[CRC_W-2:0], 1'b0};
         end
      end
      crc_nx = absorb ? stepped : crc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (load_init) begin
         crc_q <= INIT;
      end else begin
         crc_q <= crc_nx;
      end
   end

endmodule

// File: rtl/cfgp_cmd_engine.sv
module cfgp_cmd_engine
   import cfgp_pkg::*;
#(
   parameter int unsigned DIM_W = 16,
   parameter int unsigned PAY_W = 32,
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             sync_hit,
   input  logic [DIM_W-1:0] cur_width,
   input  logic [DIM_W-1:0] cur_height,
   input  logic [CRC_W-1:0] crc_nx,
   output logic             hunting,
   output logic             crc_absorb,
   output logic             crc_load,
   output logic             exec,
   output logic [3:0]       exec_op,
   output logic [PAY_W-1:0] exec_val,
   output logic             synced,
   output logic             blk_valid,
   output logic [7:0]       blk_byte,
   output logic             blk_is_bram,
   output logic             wake_pulse,
   output logic             proto_err,
   output logic             crc_err
);
   localparam int unsigned CNT_W = 2 * DIM_W;

   prs_state_t       state_q;
   logic [3:0]       op_q;
   logic [3:0]       left_q;
   logic [PAY_W-1:0] arg_q;
   logic [CNT_W-1:0] cnt_q;
   logic             trail_second_q;

   logic [3:0]       cmd_op;
   logic [3:0]       cmd_len;
   logic             is_sys;
   logic             blk_start;
   logic [CNT_W-1:0] blk_prod;
   logic [CNT_W-1:0] blk_len;
   logic             bad_cmd;
   logic             bad_val;
   logic             bad_trail;
   logic             crc_fail;

   assign cmd_op  = in_byte[7:4];
   assign cmd_len = in_byte[3:0];
   assign hunting = (state_q == ST_HUNT);

   always_comb begin
      exec     = 1'b0;
      exec_op  = (state_q == ST_CMD) ? cmd_op : op_q;
      exec_val = '0;
      if (in_valid) begin
         case (state_q)
            ST_CMD: exec = (cmd_len == 4'd0);
            ST_ARG: begin
               exec     = (left_q == 4'd1);
               exec_val = {arg_q[PAY_W-9:0], in_byte};
            end
            default: exec = 1'b0;
         endcase
      end
   end

   assign crc_absorb = in_valid && !hunting;
   assign is_sys     = exec && (exec_op == OP_SYS);
   assign blk_start  = is_sys && ((exec_val == PAY_W'(SUB_CFG_WR)) ||
                                  (exec_val == PAY_W'(SUB_RAM_WR)));
   assign crc_load   = sync_hit || (is_sys && (exec_val == PAY_W'(SUB_CRC_CLR)));
   assign blk_prod   = {{DIM_W{1'b0}}, cur_width} * {{DIM_W{1'b0}}, cur_height};
   assign blk_len    = blk_prod >> 3;

   always_comb begin
      bad_val = 1'b0;
      if (exec) begin
         case (exec_op)
            OP_SYS: bad_val = !((exec_val >= PAY_W'(SUB_CFG_WR) &&
                                 exec_val <= PAY_W'(SUB_WAKE)) ||
                                exec_val == PAY_W'(SUB_REBOOT));
            OP_BOOTMODE: bad_val = !(exec_val == PAY_W'(BM_WARM_OFF) ||
                                     exec_val == PAY_W'(BM_COLD_ON) ||
                                     exec_val == PAY_W'(BM_WARM_ON));
            OP_OSC: bad_val = (exec_val > PAY_W'(OSC_MAX));
            default: bad_val = 1'b0;
         endcase
      end
   end

   assign bad_cmd   = in_valid && (state_q == ST_CMD) && !opcode_known(cmd_op);
   assign bad_trail = in_valid && (state_q == ST_TRAIL) && (in_byte != 8'h00);
   assign crc_fail  = exec && (exec_op == OP_CRCCHK) && (crc_nx != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= ST_HUNT;
         op_q           <= '0;
         left_q         <= '0;
         arg_q          <= '0;
         cnt_q          <= '0;
         trail_second_q <= 1'b0;
         synced         <= 1'b0;
         blk_valid      <= 1'b0;
         blk_byte       <= '0;
         blk_is_bram    <= 1'b0;
         wake_pulse     <= 1'b0;
         proto_err      <= 1'b0;
         crc_err        <= 1'b0;
      end else begin
         blk_valid  <= in_valid && (state_q == ST_DATA);
         blk_byte   <= in_byte;
         wake_pulse <= is_sys && (exec_val == PAY_W'(SUB_WAKE));
         proto_err  <= proto_err || bad_cmd || bad_val || bad_trail;
         crc_err    <= crc_err || crc_fail;
         if (sync_hit) begin
            synced <= 1'b1;
         end
         if (blk_start) begin
            blk_is_bram <= (exec_val == PAY_W'(SUB_RAM_WR));
         end

         if (in_valid) begin
            case (state_q)
               ST_HUNT: begin
                  if (sync_hit) begin
                     state_q <= ST_CMD;
                  end
               end
               ST_CMD: begin
                  if (cmd_len != 4'd0) begin
                     state_q <= ST_ARG;
                     op_q    <= cmd_op;
                     left_q  <= cmd_len;
                     arg_q   <= '0;
                  end else if (blk_start) begin
                     state_q        <= (blk_len == '0) ? ST_TRAIL : ST_DATA;
                     cnt_q          <= blk_len;
                     trail_second_q <= 1'b0;
                  end
               end
               ST_ARG: begin
                  arg_q  <= {arg_q[PAY_W-9:0], in_byte};
                  left_q <= left_q - 1'b1;
                  if (left_q == 4'd1) begin
                     if (blk_start) begin
                        state_q        <= (blk_len == '0) ? ST_TRAIL : ST_DATA;
                        cnt_q          <= blk_len;
                        trail_second_q <= 1'b0;
                     end else begin
                        state_q <= ST_CMD;
                     end
                  end
               end
               ST_DATA: begin
                  cnt_q <= cnt_q - 1'b1;
                  if (cnt_q == CNT_W'(1)) begin
                     state_q <= ST_TRAIL;
                  end
               end
               ST_TRAIL: begin
                  trail_second_q <= 1'b1;
                  if (trail_second_q) begin
                     state_q <= ST_CMD;
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgp_cfg_regs.sv
module cfgp_cfg_regs
   import cfgp_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned DIM_W  = 16,
   parameter int unsigned BOOT_W = 24,
   parameter int unsigned PAY_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec,
   input  logic [3:0]        exec_op,
   input  logic [PAY_W-1:0]  exec_val,
   output logic [BANK_W-1:0] bank_num,
   output logic [DIM_W-1:0]  bank_width,
   output logic [DIM_W-1:0]  bank_height,
   output logic [DIM_W-1:0]  bank_offset,
   output logic [BOOT_W-1:0] boot_addr,
   output logic [1:0]        osc_range,
   output logic              warm_boot_en,
   output logic              cold_boot_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_num     <= '0;
         bank_width   <= '0;
         bank_height  <= '0;
         bank_offset  <= '0;
         boot_addr    <= '0;
         osc_range    <= '0;
         warm_boot_en <= 1'b0;
         cold_boot_en <= 1'b0;
      end else if (exec) begin
         case (exec_op)
            OP_BANK:     bank_num    <= exec_val[BANK_W-1:0];
            OP_WIDTH:    bank_width  <= exec_val[DIM_W-1:0];
            OP_HEIGHT:   bank_height <= exec_val[DIM_W-1:0];
            OP_OFFSET:   bank_offset <= exec_val[DIM_W-1:0];
            OP_BOOTADDR: boot_addr   <= exec_val[BOOT_W-1:0];
            OP_OSC: begin
               if (exec_val <= PAY_W'(OSC_MAX)) begin
                  osc_range <= exec_val[1:0];
               end
            end
            OP_BOOTMODE: begin
               if (exec_val == PAY_W'(BM_WARM_OFF)) begin
                  warm_boot_en <= 1'b0;
               end else if (exec_val == PAY_W'(BM_COLD_ON)) begin
                  cold_boot_en <= 1'b1;
               end else if (exec_val == PAY_W'(BM_WARM_ON)) begin
                  warm_boot_en <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
   parameter int unsigned BANK_W     = 2,
   parameter int unsigned DIM_W      = 16,
   parameter int unsigned BOOT_W     = 24,
   parameter int unsigned PAY_W      = 32,
   parameter int unsigned SYNC_BYTES = 4,
   parameter logic [8*SYNC_BYTES-1:0] SYNC_WORD = 32'h7EAA997E,
   parameter logic [15:0] CRC_POLY   = 16'h1021,
   parameter logic [15:0] CRC_INIT   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              synced,
   output logic [BANK_W-1:0] bank_num,
   output logic [DIM_W-1:0]  bank_width,
   output logic [DIM_W-1:0]  bank_height,
   output logic [DIM_W-1:0]  bank_offset,
   output logic [BOOT_W-1:0] boot_addr,
   output logic [1:0]        osc_range,
   output logic              warm_boot_en,
   output logic              cold_boot_en,
   output logic              blk_valid,
   output logic [7:0]        blk_byte,
   output logic              blk_is_bram,
   output logic              wake_pulse,
   output logic              proto_err,
   output logic              crc_err
);
   localparam int unsigned CRC_W = 16;

   generate
      if (PAY_W < 16 || PAY_W % 8 != 0) begin : g_bad_pay
         $error("PAY_W must be a multiple of 8 and at least 16");
      end
      if (DIM_W > PAY_W || BOOT_W > PAY_W || BANK_W > PAY_W || BANK_W == 0) begin : g_bad_field
         $error("field widths must fit in PAY_W");
      end
      if (SYNC_BYTES == 0) begin : g_bad_sync
         $error("SYNC_BYTES must be at least 1");
      end
   endgenerate

   logic             hunting;
   logic             sync_hit;
   logic             crc_absorb;
   logic             crc_load;
   logic [CRC_W-1:0] crc_nx;
   logic             exec;
   logic [3:0]       exec_op;
   logic [PAY_W-1:0] exec_val;

   cfgp_sync_hunt #(
      .SYNC_BYTES (SYNC_BYTES),
      .SYNC_WORD  (SYNC_WORD)
   ) u_hunt (
      .clk     (clk),
      .rst_n   (rst_n),
      .hunting (hunting),
      .shift   (in_valid),
      .byte_in (in_byte),
      .hit     (sync_hit)
   );

   cfgp_crc16 #(
      .CRC_W (CRC_W),
      .POLY  (CRC_POLY),
      .INIT  (CRC_INIT)
   ) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_init (crc_load),
      .absorb    (crc_absorb),
      .byte_in   (in_byte),
      .crc_nx    (crc_nx)
   );

   cfgp_cmd_engine #(
      .DIM_W (DIM_W),
      .PAY_W (PAY_W),
      .CRC_W (CRC_W)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_byte     (in_byte),
      .sync_hit    (sync_hit),
      .cur_width   (bank_width),
      .cur_height  (bank_height),
      .crc_nx      (crc_nx),
      .hunting     (hunting),
      .crc_absorb  (crc_absorb),
      .crc_load    (crc_load),
      .exec        (exec),
      .exec_op     (exec_op),
      .exec_val    (exec_val),
      .synced      (synced),
      .blk_valid   (blk_valid),
      .blk_byte    (blk_byte),
      .blk_is_bram (blk_is_bram),
      .wake_pulse  (wake_pulse),
      .proto_err   (proto_err),
      .crc_err     (crc_err)
   );

   cfgp_cfg_regs #(
      .BANK_W (BANK_W),
      .DIM_W  (DIM_W),
      .BOOT_W (BOOT_W),
      .PAY_W  (PAY_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec         (exec),
      .exec_op      (exec_op),
      .exec_val     (exec_val),
      .bank_num     (bank_num),
      .bank_width   (bank_width),
      .bank_height  (bank_height),
      .bank_offset  (bank_offset),
      .boot_addr    (boot_addr),
      .osc_range    (osc_range),
      .warm_boot_en (warm_boot_en),
      .cold_boot_en (cold_boot_en)
   );

endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk #(
   parameter int unsigned DIM_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             synced,
   input logic [DIM_W-1:0] bank_width,
   input logic [1:0]       osc_range,
   input logic             blk_valid,
   input logic             wake_pulse,
   input logic             proto_err,
   input logic             crc_err
);

   p_sync_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      synced |=> synced);

   p_cfg_frozen_hunt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !synced |=> $stable(bank_width));

   p_osc_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      osc_range != 2'd3);

   p_blk_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> synced);

   p_blk_from_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> $past(in_valid));

   p_crc_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |=> crc_err);

   p_proto_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

endmodule

bind cfg_stream_parser cfg_stream_parser_chk #(.DIM_W(DIM_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .synced     (synced),
   .bank_width (bank_width),
   .osc_range  (osc_range),
   .blk_valid  (blk_valid),
   .wake_pulse (wake_pulse),
   .proto_err  (proto_err),
   .crc_err    (crc_err)
);

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;
   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  in_byte;
   logic        synced;
   logic [1:0]  bank_num;
   logic [15:0] bank_width;
   logic [15:0] bank_height;
   logic [15:0] bank_offset;
   logic [23:0] boot_addr;
   logic [1:0]  osc_range;
   logic        warm_boot_en;
   logic        cold_boot_en;
   logic        blk_valid;
   logic [7:0]  blk_byte;
   logic        blk_is_bram;
   logic        wake_pulse;
   logic        proto_err;
   logic        crc_err;

   int          n_checks;
   int          n_fail;
   logic        tb_track;
   logic [15:0] tb_crc;

   cfg_stream_parser u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .synced       (synced),
      .bank_num     (bank_num),
      .bank_width   (bank_width),
      .bank_height  (bank_height),
      .bank_offset  (bank_offset),
      .boot_addr    (boot_addr),
      .osc_range    (osc_range),
      .warm_boot_en (warm_boot_en),
      .cold_boot_en (cold_boot_en),
      .blk_valid    (blk_valid),
      .blk_byte     (blk_byte),
      .blk_is_bram  (blk_is_bram),
      .wake_pulse   (wake_pulse),
      .proto_err    (proto_err),
      .crc_err      (crc_err)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) begin
         r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      end
      return r;
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      if (tb_track) tb_crc = crc_byte(tb_crc, b);
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      in_byte  = 8'h00;
      tb_track = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_sync();
      send(8'h7E); send(8'hAA); send(8'h99); send(8'h7E);
      tb_track = 1'b1;
      tb_crc   = 16'hFFFF;
   endtask

   task automatic t_reset();
      do_reset();
      check(synced, 0, "R10 synced");
      check({bank_num, bank_width, bank_height, bank_offset}, 0, "R10 bank regs");
      check({boot_addr, osc_range, warm_boot_en, cold_boot_en}, 0, "R10 boot regs");
      check({blk_valid, wake_pulse, proto_err, crc_err}, 0, "R10 flags");
   endtask

   task automatic t_sync();
      do_reset();
      send(8'hFF); send(8'h00); send(8'h68); send(8'h69);
      send(8'h00); send(8'hFF); send(8'h71); send(8'h00);
      send(8'h11); send(8'h03);
      send(8'h00); send(8'hFF);
      send(8'h7E); send(8'hAA); send(8'h99); send(8'h00);
      check({synced, bank_num}, 0, "R1 preamble and partial token ignored");
      send(8'h7E); send(8'hAA); send(8'h99);
      check(synced, 0, "R1 not synced before last token byte");
      send(8'h7E);
      check(synced, 1, "R1 synced after token");
      send(8'h11); send(8'h02);
      check(bank_num, 2, "R1 commands decoded after token");
   endtask

   task automatic t_regs();
      do_reset();
      do_sync();
      send(8'h11); send(8'h03);
      check(bank_num, 3, "R2 bank");
      send(8'h62); send(8'h12);
      check(bank_width, 0, "R2 width waits for last byte");
      send(8'h34);
      check(bank_width, 16'h1234, "R2 width MSB first");
      send(8'h72); send(8'h01); send(8'h00);
      send(8'h82); send(8'h00); send(8'h40);
      check({bank_height, bank_offset}, {16'h0100, 16'h0040}, "R2 height offset");
      send(8'h43); send(8'hAB); send(8'hCD); send(8'hEF);
      check(boot_addr, 24'hABCDEF, "R2 boot address");
      send(8'h10);
      check(bank_num, 0, "R2 zero-length value 0");
      check(proto_err, 0, "R2 no error");
   endtask

   task automatic t_osc_boot();
      do_reset();
      do_sync();
      send(8'h51); send(8'h01);
      check(osc_range, 1, "R3 medium");
      send(8'h51); send(8'h02);
      check(osc_range, 2, "R3 high");
      check(proto_err, 0, "R3 legal no error");
      send(8'h51); send(8'h03);
      check({proto_err, osc_range}, {1'b1, 2'd2}, "R3 illegal kept and flagged");
      do_reset();
      do_sync();
      send(8'h91); send(8'h20);
      check({warm_boot_en, cold_boot_en}, 2'b10, "R4 warm on");
      send(8'h91); send(8'h10);
      check({warm_boot_en, cold_boot_en}, 2'b11, "R4 cold on");
      send(8'h90);
      check({warm_boot_en, cold_boot_en, proto_err}, 3'b010, "R4 warm off");
   endtask

   task automatic t_data();
      do_reset();
      do_sync();
      send(8'h62); send(8'h00); send(8'h08);
      send(8'h72); send(8'h00); send(8'h02);
      send(8'h01); send(8'h01);
      check(blk_valid, 0, "R5 no data on command");
      send(8'hA5);
      check({blk_valid, blk_byte, blk_is_bram}, {1'b1, 8'hA5, 1'b0}, "R5 cfg byte 0");
      send(8'h3C);
      check({blk_valid, blk_byte}, {1'b1, 8'h3C}, "R5 cfg byte 1");
      send(8'h00);
      check(blk_valid, 0, "R5 trailer not forwarded");
      send(8'h00);
      check({blk_valid, proto_err}, 0, "R5 trailer ok");
      send(8'h11); send(8'h01);
      check(bank_num, 1, "R5 decoding resumes");
      send(8'h01); send(8'h03);
      send(8'h5A);
      check({blk_valid, blk_byte, blk_is_bram}, {1'b1, 8'h5A, 1'b1}, "R5 ram byte");
      send(8'h66);
      send(8'h00); send(8'h01);
      check({blk_valid, proto_err}, {1'b0, 1'b1}, "R5 bad trailer");
   endtask

   task automatic t_crc();
      logic [15:0] c;
      do_reset();
      do_sync();
      send(8'h11); send(8'h02);
      send(8'h62); send(8'h00); send(8'h40);
      send(8'h22);
      c = tb_crc;
      send(c[15:8]); send(c[7:0]);
      check(crc_err, 0, "R7 correct check passes");
      send(8'h01); send(8'h05);
      tb_crc = 16'hFFFF;
      send(8'h11); send(8'h01);
      send(8'h22);
      c = tb_crc;
      send(c[15:8]); send(c[7:0]);
      check(crc_err, 0, "R6 reload to FFFF");
      send(8'h22);
      c = ~tb_crc;
      send(c[15:8]); send(c[7:0]);
      check(crc_err, 1, "R7 wrong check flagged");
      send(8'h11); send(8'h03);
      check({crc_err, bank_num}, {1'b1, 2'd3}, "R7 sticky");
   endtask

   task automatic t_proto_wake();
      do_reset();
      do_sync();
      send(8'h01); send(8'h02);
      send(8'h01); send(8'h04);
      send(8'h01); send(8'h08);
      check({proto_err, wake_pulse, bank_num, bank_width}, 0, "R8 reads and reboot no effect");
      send(8'h32); send(8'h11); send(8'h01);
      check({proto_err, bank_num}, {1'b1, 2'd0}, "R8 undefined opcode flagged, payload eaten");
      send(8'h11); send(8'h02);
      check(bank_num, 2, "R8 next command decodes");
      do_reset();
      do_sync();
      send(8'h01); send(8'h07);
      check(proto_err, 1, "R8 unknown sub-command");
      do_reset();
      do_sync();
      send(8'h01); send(8'h06);
      check(wake_pulse, 1, "R9 wake pulse");
      @(negedge clk);
      check(wake_pulse, 0, "R9 one cycle only");
   endtask

   initial begin
      n_checks = 0;
      n_fail   = 0;
      tb_track = 1'b0;
      tb_crc   = 16'hFFFF;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_byte  = 8'h00;
      t_reset();
      t_sync();
      t_regs();
      t_osc_boot();
      t_data();
      t_crc();
      t_proto_wake();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule